// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period. The stop period lasts one, one and a half, or two bit periods. The data length, the parity mode and the stop length are chosen at run time through three small configuration inputs.

Timing comes from an external enable, `baud_tick`, which pulses once per sixteenth of a bit period. The block counts these pulses to time each bit, so it contains no rate generator of its own. Characters arrive over a valid/ready handshake. The block samples the configuration together with the character, so a change to the configuration inputs during a frame does not alter that frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After synchronous reset, and whenever no frame is in flight, `tx` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `tx` drives the start bit (0) for 16 consumed baud ticks.
- R3: `cfg_len` selects the number of data bits as 5 + `cfg_len` (code 0 gives 5, code 3 gives 8). The data bits are sent bit 0 first, and each lasts 16 consumed ticks.
- R4: `cfg_parity` selects the parity mode: 0 is none, 1 is even, 2 is odd, and 3 is treated as none. In the even and odd modes, one 16-tick parity bit follows the data. It makes the count of ones across the sent data bits plus the parity bit even or odd, as selected.
- R5: The frame ends with `tx` held at 1. `cfg_stop` sets the stop length: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks.
- R6: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the edge that consumes the last stop tick. While the block is busy, `in_valid` has no effect and no extra frame is produced.
- R7: The data word and all three configuration fields are captured at acceptance. Changing them during a frame does not alter the frame being sent.
- R8: A frame lasts exactly 16 × (1 + data bits + parity bits) + stop ticks consumed ticks, and `tx` changes only on edges that consume a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can accept a character |
| in_data | input | 8 | Character; bit 0 is sent first |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_parity | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| tx | output | 1 | Serial output line |
| busy | output | 1 | A frame is in flight |

## Verification
Every result is due a fixed number of consumed baud ticks after acceptance. The start bit appears in the first cycle after the accepting edge. Bit i of the frame is on the line from tick 16·i through tick 16·i+15. `busy` falls right after the edge that consumes the final stop tick. The monitor counts only the ticks the design can consume, samples each bit at its eighth tick and compares it with the frame the driver queued. It checks each frame's total length in ticks at the moment `busy` falls, and samples 2 ns after each rising edge so that no value is read while it changes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_RSVD  = 2'd3
    } parity_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_RSVD     = 2'd3
    } stop_e;

    typedef struct packed {
        logic [1:0] len_code;
        parity_e    parity;
        stop_e      stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    localparam int unsigned MIN_DATA_BITS = 5;

    function automatic int unsigned data_bits(input logic [1:0] len_code);
        return MIN_DATA_BITS + int'(len_code);
    endfunction

    function automatic logic parity_used(input parity_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic parity_value(input logic [7:0] d,
                                          input logic [1:0] len_code,
                                          input parity_e    p);
        logic [7:0] mask;
        logic       ones_odd;
        mask     = 8'hFF >> (3 - int'(len_code));
        ones_odd = ^(d & mask);
        return (p == PAR_ODD) ? ~ones_odd : ones_odd;
    endfunction

    function automatic int unsigned stop_ticks(input stop_e s, input int unsigned os);
        case (s)
            STOP_ONE:      return os;
            STOP_ONE_HALF: return os + os / 2;
            default:       return 2 * os;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_tick_timer.sv
module uart_tx_tick_timer #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = tick && !clear && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + CW'(1);
        end
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (cnt_q < limit)) else $error("timer past limit"); // R8

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         lsb
);
    logic [W-1:0] sr_q;

    assign lsb = sr_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= load_data;
        end else if (shift) begin
            sr_q <= {1'b1, sr_q[W-1:1]};
        end
    end

    AST_SHIFT_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && shift)) else $error("load and shift together"); // R6

    AST_SHIFT_MOVES_LSB: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (lsb == $past(sr_q[1]))) else $error("shift order"); // R3

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    output logic              tx,
    output logic              busy
);
    localparam int unsigned CW = $clog2(2 * OVERSAMPLE + 1);
    localparam int unsigned IW = $clog2(DATA_W);

    tx_state_e     state_q, state_d;
    frame_cfg_t    cfg_q;
    logic          par_q;
    logic [IW-1:0] idx_q;
    logic          accept;
    logic          bit_done;
    logic          shift_en;
    logic          sh_lsb;
    logic          last_data;
    logic [CW-1:0] limit;

    assign accept    = in_valid && (state_q == ST_IDLE);
    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign last_data = (int'(idx_q) == int'(data_bits(cfg_q.len_code)) - 1);
    assign shift_en  = bit_done && (state_q == ST_DATA);
    assign limit     = (state_q == ST_STOP) ? CW'(stop_ticks(cfg_q.stop, OVERSAMPLE))
                                            : CW'(OVERSAMPLE);

    uart_tx_tick_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q == ST_IDLE),
        .tick  (baud_tick),
        .limit (limit),
        .done  (bit_done)
    );

    uart_tx_shifter #(.W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (in_data),
        .shift     (shift_en),
        .lsb       (sh_lsb)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && last_data)
                           state_d = parity_used(cfg_q.parity) ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_d = ST_STOP;
            ST_STOP:   if (bit_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '{len_code: 2'd3, parity: PAR_NONE, stop: STOP_ONE};
            par_q   <= 1'b1;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q <= '{len_code: cfg_len,
                           parity:   parity_e'(cfg_parity),
                           stop:     stop_e'(cfg_stop)};
                par_q <= parity_value(in_data, cfg_len, parity_e'(cfg_parity));
                idx_q <= '0;
            end else if (shift_en) begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    always_comb begin
        case (state_q)
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = sh_lsb;
            ST_PARITY: tx = par_q;
            default:   tx = 1'b1;
        endcase
    end

    AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !tx && !in_ready)) else $error("no start"); // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(cfg_q)) else $error("cfg moved"); // R7

    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(baud_tick)) else $error("frame ended off tick"); // R6

    AST_TX_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && !$past(baud_tick)) |-> $stable(tx)) else $error("tx moved"); // R8

    AST_DATA_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_DATA && state_q != ST_DATA) |->
        (int'($past(idx_q)) == int'(data_bits(cfg_q.len_code)) - 1)) else $error("bit count"); // R3

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> tx) else $error("line not idle"); // R1

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

    typedef struct {
        logic [11:0] bits;
        int          ndata;
        int          npar;
        int          total;
        bit          scrambled;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       tx;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    frame_t exp_q[$];

    always #5 clk = ~clk;

    uart_frame_tx dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .tx(tx), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // tick generator: one tick every second cycle
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            baud_tick = (cyc % 2 == 0);
            cyc++;
        end
    end

    function automatic frame_t build(input logic [7:0] d, input logic [1:0] len,
                                     input logic [1:0] par, input logic [1:0] stp,
                                     input bit scr);
        frame_t f;
        int n;
        logic ones;
        n = 5 + int'(len);
        f.bits = '1;
        f.bits[0] = 1'b0;
        ones = 1'b0;
        for (int i = 0; i < n; i++) begin
            f.bits[i+1] = d[i];
            ones ^= d[i];
        end
        f.npar = (par == 2'd1 || par == 2'd2) ? 1 : 0;
        if (par == 2'd1) f.bits[n+1] = ones;
        if (par == 2'd2) f.bits[n+1] = ~ones;
        f.ndata = n;
        f.total = 16 * (1 + n + f.npar) + ((stp == 2'd0) ? 16 : (stp == 2'd1) ? 24 : 32);
        f.scrambled = scr;
        return f;
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] len,
                        input logic [1:0] par, input logic [1:0] stp, input bit scr);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d;
        cfg_len = len; cfg_parity = par; cfg_stop = stp;
        exp_q.push_back(build(d, len, par, stp, scr));
        @(negedge clk);
        in_valid = 1'b0;
        if (scr) begin
            in_data = ~d; cfg_len = len + 2'd1;
            cfg_parity = par + 2'd1; cfg_stop = stp + 2'd1;
            in_valid = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                chk(in_ready == 1'b0, "R6 ready held low while busy", in_ready, 0);
            end
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    initial begin
        frame_t cur;
        bit prev_busy = 0;
        bit active = 0;
        int ticks = 0;
        int ferr = 0;
        forever begin
            @(posedge clk); #2;
            if (rst) begin
                prev_busy = 0; active = 0;
            end else begin
                if (busy && !prev_busy) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 unexpected frame", 1, 0);
                    end else begin
                        cur = exp_q.pop_front();
                        ticks = 0; ferr = 0; active = 1;
                    end
                end else if (active) begin
                    if (baud_tick) ticks++;
                    if (!busy) begin
                        chk(ticks == cur.total, "R8 frame length in ticks", ticks, cur.total);
                        chk(tx == 1'b1, "R1 line idle after frame", tx, 1);
                        if (cur.scrambled)
                            chk(ferr == 0, "R7 latched frame unaffected", ferr, 0);
                        active = 0;
                    end else if (baud_tick && (ticks % 16 == 8)) begin
                        int idx;
                        logic e;
                        string tag;
                        idx = ticks / 16;
                        e = (idx < 12) ? cur.bits[idx] : 1'b1;
                        if (idx == 0) tag = "R2 start bit";
                        else if (idx <= cur.ndata) tag = "R3 data bit";
                        else if (cur.npar == 1 && idx == cur.ndata + 1) tag = "R4 parity bit";
                        else tag = "R5 stop level";
                        if (tx !== e) ferr++;
                        chk(tx === e, tag, tx, e);
                    end
                end
                prev_busy = busy;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx == 1'b1, "R1 reset tx", tx, 1);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);

        send(8'hA5, 2'd3, 2'd0, 2'd0, 0);  // 8N1
        send(8'h3C, 2'd3, 2'd1, 2'd0, 0);  // 8E1
        send(8'h3D, 2'd3, 2'd2, 2'd2, 0);  // 8O2
        send(8'hF1, 2'd0, 2'd1, 2'd1, 0);  // 5E1.5, upper bits ignored
        send(8'h2A, 2'd1, 2'd2, 2'd1, 0);  // 6O1.5
        send(8'h55, 2'd2, 2'd3, 2'd3, 0);  // 7, reserved parity/stop
        send(8'h00, 2'd3, 2'd2, 2'd0, 1);  // 8O1, inputs changed mid-frame
        send(8'hFF, 2'd0, 2'd0, 2'd2, 1);  // 5N2, inputs changed mid-frame
        send(8'h81, 2'd3, 2'd1, 2'd1, 0);  // back to back

        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all frames sent", exp_q.size(), 0);
        chk(in_ready == 1'b1 && tx == 1'b1, "R1 idle at end", {in_ready, tx}, 3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule